// File: doc/BRIEF.md
# Three-Line Masked Event Interrupt Aggregator

This block gathers 96 single-cycle event pulses from peripherals into three 32-bit sticky status words. Each pending event is routed onto three interrupt lines through a 3x3 matrix of 32-bit mask words. There is one mask group per line, and each group holds one mask word for every status word. Software clears an event by writing a one to its status bit. It enables or blocks an event on a given line by changing that group's mask word. Each interrupt line is level-sensitive. It stays high while any event that is both set and enabled for its group remains pending. Line 0 carries the highest priority, line 1 the middle priority and line 2 the lowest.

For each line, a read-only vector register reports the lowest-numbered event that is pending and enabled on that line, together with a valid flag. An interrupt handler can therefore find its source in a single read. Register access uses a request channel and a read-response channel, each with valid/ready. A request is accepted only when the response slot is free or is draining in the same cycle. A read response stays stable until it is taken. Writes produce no response.

Top module: `evt_irq_aggregator`

## Requirements
- R1: A one-cycle pulse on event input n sets bit n mod 32 of status word n/32, where status word w is at byte offset 4*w (0x00, 0x04, 0x08). The bit stays set until it is acknowledged.
- R2: Writing a status word clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R3: When an event pulse and a write-1 acknowledge reach the same status bit in the same cycle, the bit ends up set.
- R4: Mask word w of group g can be read and written at byte offset 0x10 + 0x10*g + 4*w. A mask bit of 1 enables that event onto line g, and a 0 blocks it.
- R5: irq_o[g] is the OR over all 96 bits of (status AND mask group g). It is registered, so it changes on the clock edge after the edge that updated the status or mask.
- R6: The read-only word at offset 0x40 + 4*g returns the index (0..95) of the lowest-numbered event pending on line g in bits 6:0, with a valid flag in bit 31. When nothing is pending on that line, the word reads as zero.
- R7: After reset, all status words, all mask words and all interrupt lines are zero.
- R8: Reads of unmapped or unaligned offsets return zero. Writes to those offsets, and writes to the vector words, change no state.
- R9: req_ready equals (not rsp_valid) or rsp_ready. A request moves on a clock edge where req_valid and req_ready are both high. The read data appears on rsp_rdata with rsp_valid on the following edge. While rsp_valid is high and rsp_ready is low, rsp_valid and rsp_rdata hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Consumer takes the read response |
| rsp_rdata | output | 32 | Read response data |
| evt_i | input | 96 | Event pulses, bit n = event n |
| irq_o | output | 3 | Interrupt lines, bit 0 highest priority |

## Verification
Two functions can act on the same status bit in the same cycle: an event pulse setting the bit, and a software write-1 acknowledge clearing it. The bench drives a pulse on event 5 in the exact cycle where a write that acknowledges bits 5 and 3 of word 0 is accepted. It then reads word 0 back and expects bit 5 set and bit 3 cleared. A second overlap is a new read request arriving while an earlier response is held back. The bench holds rsp_ready low and checks three things: req_ready drops, and rsp_valid and rsp_rdata stay fixed. A scoreboard then compares the response once it drains.

// File: rtl/evt_agg_pkg.sv
package evt_agg_pkg;

  localparam int VEC_PAGE  = 4;   // offset 0x40 page
  localparam int MASK_PAGE = 1;   // first mask page, 0x10

  typedef enum logic [1:0] {
    RG_NONE = 2'd0,
    RG_STAT = 2'd1,
    RG_MASK = 2'd2,
    RG_VEC  = 2'd3
  } region_e;

  typedef struct packed {
    region_e    region;
    logic [1:0] grp;
    logic [1:0] word;
  } decode_t;

endpackage

// File: rtl/evt_status_bank.sv
module evt_status_bank #(
  parameter int WORDS  = 3,
  parameter int WORD_W = 32,
  localparam int EVENTS = WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVENTS-1:0] evt_i,
  input  logic              ack_en,
  input  logic [1:0]        ack_word,
  input  logic [WORD_W-1:0] ack_data,
  output logic [EVENTS-1:0] status_o
);

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] clr;

    always_comb begin
      clr = '0;
      if (ack_en && (int'(ack_word) == w)) clr = ack_data;
    end

    // a new pulse takes precedence over a same-cycle acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= (word_q & ~clr) | evt_i[w*WORD_W +: WORD_W];
    end

    assign status_o[w*WORD_W +: WORD_W] = word_q;
  end

endmodule

// File: rtl/evt_mask_bank.sv
module evt_mask_bank #(
  parameter int WORDS  = 3,
  parameter int WORD_W = 32,
  localparam int EVENTS = WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_word,
  input  logic [WORD_W-1:0] wr_data,
  output logic [EVENTS-1:0] mask_o
);

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                word_q <= '0;
      else if (wr_en && (int'(wr_word) == w))    word_q <= wr_data;
    end

    assign mask_o[w*WORD_W +: WORD_W] = word_q;
  end

endmodule

// File: rtl/evt_lowest_first.sv
module evt_lowest_first #(
  parameter int N     = 96,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     pend_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);

  // scan from the top so the lowest set bit is the last one taken
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/evt_irq_aggregator.sv
module evt_irq_aggregator
  import evt_agg_pkg::*;
#(
  parameter int WORDS  = 3,
  parameter int WORD_W = 32,
  parameter int LINES  = 3,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [DATA_W-1:0]       rsp_rdata,
  input  logic [WORDS*WORD_W-1:0] evt_i,
  output logic [LINES-1:0]        irq_o
);

  localparam int EVENTS = WORDS * WORD_W;
  localparam int IDX_W  = $clog2(EVENTS);
  localparam int PAD_W  = DATA_W - 1 - IDX_W;

  // ---------------- request decode ----------------
  logic    req_fire;
  logic    wr_fire;
  decode_t dec;

  assign req_ready = !rsp_valid || rsp_ready;
  assign req_fire  = req_valid && req_ready;
  assign wr_fire   = req_fire && req_write;

  always_comb begin
    dec = '{region: RG_NONE, grp: 2'd0, word: 2'd0};
    if (req_addr[1:0] == 2'b00) begin
      if (int'(req_addr[ADDR_W-1:4]) == 0 && int'(req_addr[3:2]) < WORDS) begin
        dec.region = RG_STAT;
        dec.word   = req_addr[3:2];
      end else if (int'(req_addr[ADDR_W-1:4]) >= MASK_PAGE &&
                   int'(req_addr[ADDR_W-1:4]) < MASK_PAGE + LINES &&
                   int'(req_addr[3:2]) < WORDS) begin
        dec.region = RG_MASK;
        dec.grp    = 2'(int'(req_addr[ADDR_W-1:4]) - MASK_PAGE);
        dec.word   = req_addr[3:2];
      end else if (int'(req_addr[ADDR_W-1:4]) == VEC_PAGE &&
                   int'(req_addr[3:2]) < LINES) begin
        dec.region = RG_VEC;
        dec.grp    = req_addr[3:2];
      end
    end
  end

  // ---------------- status words ----------------
  logic [EVENTS-1:0] status_q;
  logic              ack_en;

  assign ack_en = wr_fire && (dec.region == RG_STAT);

  evt_status_bank #(.WORDS(WORDS), .WORD_W(WORD_W)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (evt_i),
    .ack_en   (ack_en),
    .ack_word (dec.word),
    .ack_data (req_wdata[WORD_W-1:0]),
    .status_o (status_q)
  );

  // ---------------- per-line masks, pending, vector ----------------
  logic [EVENTS-1:0] mask_all [LINES];
  logic [DATA_W-1:0] vec_word [LINES];
  logic [LINES-1:0]  pend_any;
  logic [LINES-1:0]  vec_valid;
  logic [LINES-1:0]  irq_q;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic              mwr;
    logic [EVENTS-1:0] pend;
    logic [IDX_W-1:0]  low_idx;

    assign mwr = wr_fire && (dec.region == RG_MASK) && (int'(dec.grp) == g);

    evt_mask_bank #(.WORDS(WORDS), .WORD_W(WORD_W)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (mwr),
      .wr_word (dec.word),
      .wr_data (req_wdata[WORD_W-1:0]),
      .mask_o  (mask_all[g])
    );

    assign pend        = status_q & mask_all[g];
    assign pend_any[g] = |pend;

    evt_lowest_first #(.N(EVENTS), .IDX_W(IDX_W)) u_low (
      .pend_i  (pend),
      .found_o (vec_valid[g]),
      .idx_o   (low_idx)
    );

    assign vec_word[g] = vec_valid[g] ? {1'b1, {PAD_W{1'b0}}, low_idx} : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q[g] <= 1'b0;
      else        irq_q[g] <= pend_any[g];
    end
  end

  assign irq_o = irq_q;

  // ---------------- read path ----------------
  logic [DATA_W-1:0] rd_data;
  logic [DATA_W-1:0] rsp_q;
  logic              rsp_v_q;

  always_comb begin
    rd_data = '0;
    unique case (dec.region)
      RG_STAT: rd_data = DATA_W'(status_q[int'(dec.word)*WORD_W +: WORD_W]);
      RG_MASK: rd_data = DATA_W'(mask_all[dec.grp][int'(dec.word)*WORD_W +: WORD_W]);
      RG_VEC:  rd_data = vec_word[dec.grp];
      default: rd_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_v_q <= 1'b0;
      rsp_q   <= '0;
    end else if (req_fire && !req_write) begin
      rsp_v_q <= 1'b1;
      rsp_q   <= rd_data;
    end else if (rsp_ready) begin
      rsp_v_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_v_q;
  assign rsp_rdata = rsp_q;

endmodule

// File: rtl/evt_irq_aggregator_chk.sv
module evt_irq_aggregator_chk #(
  parameter int EVENTS = 96,
  parameter int LINES  = 3,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [EVENTS-1:0] evt_i,
  input logic [EVENTS-1:0] status_q,
  input logic              ack_en,
  input logic [LINES-1:0]  pend_any,
  input logic [LINES-1:0]  vec_valid,
  input logic [LINES-1:0]  irq_o
);

  // R1: without an acknowledge, no set status bit clears
  p_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_en |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R3: every pulsed bit is set afterwards, acknowledge or not
  p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((status_q & $past(evt_i)) == $past(evt_i)));

  // R5: each line follows its pending OR one edge later
  p_irq_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(pend_any)));

  // R6: vector valid flag agrees with the line's pending OR
  p_vec_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid == pend_any);

  // R9: a held response is stable and blocks new requests
  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  p_ready_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

endmodule

bind evt_irq_aggregator evt_irq_aggregator_chk #(
  .EVENTS(WORDS * WORD_W), .LINES(LINES), .DATA_W(DATA_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .evt_i     (evt_i),
  .status_q  (status_q),
  .ack_en    (ack_en),
  .pend_any  (pend_any),
  .vec_valid (vec_valid),
  .irq_o     (irq_o)
);

// File: tb/evt_irq_aggregator_tb_top.sv
module evt_irq_aggregator_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int EV = 96;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic [EV-1:0] evt_i = '0;
  logic [2:0]  irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [EV-1:0] m_stat;
  logic [EV-1:0] m_mask [3];

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_irq_aggregator dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .evt_i(evt_i), .irq_o(irq_o)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // monitor: compare responses as they are taken
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected response", rsp_rdata, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rsp_rdata === e, t, rsp_rdata, e);
      end
    end
  end

  function automatic logic [31:0] exp_vec(input int g);
    logic [EV-1:0] p;
    p = m_stat & m_mask[g];
    for (int i = 0; i < EV; i++)
      if (p[i]) return {1'b1, 24'b0, 7'(i)};
    return 32'h0;
  endfunction

  function automatic logic [2:0] exp_irq();
    logic [2:0] r;
    for (int g = 0; g < 3; g++) r[g] = |(m_stat & m_mask[g]);
    return r;
  endfunction

  // all drive tasks start and end 2 time units after a rising edge
  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic issue(input bit wr, input logic [7:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    forever begin
      @(negedge clk);
      if (req_ready) begin @(posedge clk); #2; break; end
      @(posedge clk); #2;
    end
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    issue(1'b0, a, 32'h0);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    int w;
    w = int'(a[3:2]);
    issue(1'b1, a, d);
    if (a[1:0] == 0 && a[7:4] == 0 && w < 3) m_stat[w*32 +: 32] &= ~d;
    if (a[1:0] == 0 && a[7:4] >= 1 && a[7:4] <= 3 && w < 3) m_mask[a[7:4]-1][w*32 +: 32] = d;
  endtask

  task automatic pulse(input logic [EV-1:0] v);
    evt_i = v;
    step(1);
    evt_i = '0;
    m_stat |= v;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) step(1);
    step(1);
  endtask

  task automatic irq_chk(input string t);
    step(2);
    @(negedge clk);
    check(irq_o === exp_irq(), t, {29'b0, irq_o}, {29'b0, exp_irq()});
    step(1);
  endtask

  initial begin
    m_stat = '0;
    for (int g = 0; g < 3; g++) m_mask[g] = '0;
    step(3);
    rst_n = 1'b1;
    step(1);

    // reset state
    @(negedge clk);
    check(irq_o === 3'b000, "R7 irq after reset", {29'b0, irq_o}, 32'h0);
    check(rsp_valid === 1'b0, "R7 rsp_valid after reset", {31'b0, rsp_valid}, 32'h0);
    step(1);
    rd(8'h00, 32'h0, "R7 status0 reset");
    rd(8'h28, 32'h0, "R7 mask g1 w2 reset");
    rd(8'h44, 32'h0, "R7 vector1 reset");

    // events land in word n/32, bit n%32 and stay
    pulse((EV'(1) << 3) | (EV'(1) << 40) | (EV'(1) << 95));
    step(4);
    rd(8'h00, 32'h0000_0008, "R1 status0 event 3");
    rd(8'h04, 32'h0000_0100, "R1 status1 event 40");
    rd(8'h08, 32'h8000_0000, "R1 status2 event 95");
    drain();
    irq_chk("R4 no line while masks clear");

    // mask write, readback, irq latency
    wr(8'h14, 32'h0000_0100);
    @(negedge clk);
    check(irq_o[0] === 1'b0, "R5 irq0 not before one extra edge", {31'b0, irq_o[0]}, 32'h0);
    @(negedge clk);
    check(irq_o[0] === 1'b1, "R5 irq0 one edge after mask", {31'b0, irq_o[0]}, 32'h1);
    step(1);
    wr(8'h38, 32'h8000_0000);
    wr(8'h20, 32'h0000_0018);
    rd(8'h20, 32'h0000_0018, "R4 mask g1 w0 readback");
    rd(8'h14, 32'h0000_0100, "R4 mask g0 w1 readback");
    drain();
    irq_chk("R5 all three lines");

    // vectors
    rd(8'h40, exp_vec(0), "R6 vector0 event 40");
    rd(8'h44, exp_vec(1), "R6 vector1 event 3");
    rd(8'h48, exp_vec(2), "R6 vector2 event 95");
    drain();
    wr(8'h10, 32'h0000_0002);
    pulse(EV'(1) << 1);
    step(1);
    rd(8'h40, 32'h8000_0001, "R6 vector0 lowest wins");
    drain();

    // acknowledge
    wr(8'h04, 32'h0000_0100);
    wr(8'h00, 32'h0000_0000);
    rd(8'h04, 32'h0, "R2 event 40 cleared");
    rd(8'h00, 32'h0000_000A, "R2 zero bits unaffected");
    drain();
    irq_chk("R5 line follows acknowledge");
    wr(8'h00, 32'h0000_0002);
    wr(8'h08, 32'h8000_0000);
    rd(8'h40, 32'h0, "R6 vector0 empty reads zero");
    rd(8'h48, 32'h0, "R6 vector2 empty reads zero");
    drain();
    irq_chk("R5 lines drop after acknowledge");

    // set and acknowledge in the same cycle
    pulse(EV'(1) << 5);
    step(1);
    evt_i = EV'(1) << 5;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h00; req_wdata = 32'h0000_0028;
    @(negedge clk);
    check(req_ready === 1'b1, "R3 request ready for overlap", {31'b0, req_ready}, 32'h1);
    step(1);
    req_valid = 1'b0; req_write = 1'b0; evt_i = '0;
    m_stat[31:0] &= ~32'h0000_0028;
    m_stat[5] = 1'b1;
    rd(8'h00, 32'h0000_0020, "R3 set beats acknowledge");
    drain();

    // unmapped space and read-only vector words
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h3C, 32'hFFFF_FFFF);
    wr(8'h01, 32'hFFFF_FFFF);
    rd(8'h0C, 32'h0, "R8 unmapped 0x0C");
    rd(8'h4C, 32'h0, "R8 unmapped 0x4C");
    rd(8'h02, 32'h0, "R8 unaligned 0x02");
    rd(8'hFC, 32'h0, "R8 unmapped 0xFC");
    rd(8'h00, 32'h0000_0020, "R8 status0 untouched by stray writes");
    rd(8'h10, 32'h0000_0002, "R8 mask g0 w0 untouched");
    rd(8'h40, exp_vec(0), "R8 vector0 unchanged");
    drain();

    // back-pressure
    rsp_ready = 1'b0;
    rd(8'h20, 32'h0000_0018, "R9 held response delivered");
    @(negedge clk);
    check(rsp_valid === 1'b1, "R9 rsp_valid held", {31'b0, rsp_valid}, 32'h1);
    check(req_ready === 1'b0, "R9 req_ready low while held", {31'b0, req_ready}, 32'h0);
    step(3);
    @(negedge clk);
    check(rsp_rdata === 32'h0000_0018, "R9 rsp_rdata stable", rsp_rdata, 32'h0000_0018);
    step(1);
    rsp_ready = 1'b1;
    drain();
    @(negedge clk);
    check(rsp_valid === 1'b0, "R9 response drained", {31'b0, rsp_valid}, 32'h0);
    check(exp_q.size() == 0, "R9 scoreboard empty", exp_q.size(), 32'h0);

    done = 1'b1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", 32'h0, 32'h0);
      report();
    end
  end

endmodule